// File: doc/BRIEF.md
# Turnaround-Free Synchronous SRAM Model

This block is a synthesizable behavioural model of a synchronous static RAM with flow-through read data and no idle cycle when the data bus changes direction. Each active clock edge captures an address and command. The data transfer for that command takes place in the clock cycle that follows. A read drives data straight from the array during that cycle, with no output register. A write takes its data from the input bus at the edge that closes that cycle. Because every command has the same one-cycle lag, reads and writes can alternate on every cycle.

Commands are qualified by three chip selects of mixed polarity and by a load/advance strobe. When the strobe is set to advance, an operation in progress continues at the next word of its aligned four-word group, in the same direction. An active-low clock enable freezes the whole model while it is high. An asynchronous output enable can cut the bus drive at any time. The bus is split into separate input, output and drive-enable ports, so that a bench or a pad wrapper can join them. The stream handshake of the house style does not fit a memory bus, so every pin is a plain level signal.

Top module: `turnfree_sram`

## Requirements
- R1: A read command captured at an active edge makes `dq_oe` high and puts the stored word on `dq_out` for the whole of the next clock cycle, taken combinationally from the array.
- R2: For a write command captured at an active edge, the word on `dq_in` at the next active edge is stored at the captured address.
- R3: Reads and writes may be issued on consecutive cycles in any order with no idle cycle, and a read issued right after a write to the same address returns the newly written word.
- R4: During a write, `lane_we_n[i]` low updates bits `[i*LANE_W +: LANE_W]` of the word and leaves all other lanes unchanged. For an advancing write, the lane enables are sampled again at each step.
- R5: While `cke_n` is high, all other synchronous inputs are ignored. No pending write is committed, and a pending read keeps driving the same word.
- R6: A new command starts only when `sel0_n`=0, `sel1`=1, `sel2_n`=0 and `burst_next`=0. Any other select pattern with `burst_next`=0 starts nothing, and no write happens.
- R7: After a deselect, the transfer pending from the previous command still completes: read data is driven, or write data is stored.
- R8: `dq_oe` is low in the cycle after a deselect and in the cycle after a write command is captured.
- R9: `oe_n` high forces `dq_oe` low immediately, without waiting for a clock edge.
- R10: With `burst_next`=1 and an operation in progress, the address steps to `(addr & ~3) | ((addr+1) & 3)`, a wrapping walk through an aligned four-word group, in the same direction. With no operation in progress, `burst_next`=1 has no effect.
- R11: While `rst_n` is low and after its release, no operation is pending and `dq_oe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset of the command pipeline |
| cke_n | input | 1 | Active-low clock enable; high freezes the model |
| sel0_n | input | 1 | Chip select, active low |
| sel1 | input | 1 | Chip select, active high |
| sel2_n | input | 1 | Chip select, active low |
| burst_next | input | 1 | 0 loads a new command, 1 advances the current one |
| wr_n | input | 1 | Command direction: 1 read, 0 write |
| addr | input | AW | Word address |
| lane_we_n | input | LANES | Per-lane write enables, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| dq_in | input | LANES*LANE_W | Write data bus |
| dq_out | output | LANES*LANE_W | Flow-through read data |
| dq_oe | output | 1 | Drive enable for the read data |

## Verification
The bench targets read-after-write to the same word. A design that buffers write data for an extra cycle would return the old word there. It also freezes the clock enable while a write is pending and drives junk on the inputs, which catches a model that commits writes or loads new commands while stalled. It checks the byte lanes of partial writes, so a swapped or inverted lane enable shows up as corrupted neighbouring lanes. Finally, it runs burst walks that must wrap inside the aligned group, and it lowers the drive enable between clock edges, which exposes a registered output enable.

// File: rtl/turnfree_pkg.sv
package turnfree_pkg;
  typedef enum logic {
    OP_RD = 1'b0,
    OP_WR = 1'b1
  } op_e;

  localparam int unsigned GROUP_WORDS = 4;
endpackage

// File: rtl/turnfree_ctrl.sv
module turnfree_ctrl
  import turnfree_pkg::*;
#(
  parameter int unsigned AW    = 4,
  parameter int unsigned LANES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cke_n,
  input  logic             sel0_n,
  input  logic             sel1,
  input  logic             sel2_n,
  input  logic             burst_next,
  input  logic             wr_n,
  input  logic [AW-1:0]    addr,
  input  logic [LANES-1:0] lane_we_n,
  output logic             pend_valid,
  output op_e              pend_op,
  output logic [AW-1:0]    pend_addr,
  output logic [LANES-1:0] pend_be
);
  localparam logic [AW-1:0] GROUP_MASK = AW'(GROUP_WORDS - 1);

  logic          selected;
  logic [AW-1:0] step_addr;

  assign selected  = !sel0_n && sel1 && !sel2_n;
  assign step_addr = (pend_addr & ~GROUP_MASK) | ((pend_addr + AW'(1)) & GROUP_MASK);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_valid <= 1'b0;
      pend_op    <= OP_RD;
      pend_addr  <= '0;
      pend_be    <= '0;
    end else if (!cke_n) begin
      if (!burst_next) begin
        pend_valid <= selected;
        if (selected) begin
          pend_op   <= wr_n ? OP_RD : OP_WR;
          pend_addr <= addr;
          pend_be   <= ~lane_we_n;
        end
      end else if (pend_valid) begin
        pend_addr <= step_addr;
        pend_be   <= ~lane_we_n;
      end
    end
  end

  AST_HOLD_ON_SUSPEND: assert property (@(posedge clk) disable iff (!rst_n)
    cke_n |=> ($stable(pend_addr) && $stable(pend_valid) && $stable(pend_op))); // R5

  AST_DESELECT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!cke_n && !burst_next && (sel0_n || !sel1 || sel2_n)) |=> !pend_valid); // R6

  AST_BURST_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!cke_n && burst_next && pend_valid) |=>
      (pend_addr[1:0] == $past(pend_addr[1:0]) + 2'd1) && $stable(pend_op)); // R10
endmodule

// File: rtl/turnfree_array.sv
module turnfree_array #(
  parameter int unsigned LANES  = 4,
  parameter int unsigned LANE_W = 9,
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned AW     = 4
) (
  input  logic                    clk,
  input  logic                    wr_en,
  input  logic [AW-1:0]           wr_addr,
  input  logic [LANES-1:0]        wr_be,
  input  logic [LANES*LANE_W-1:0] wr_data,
  input  logic [AW-1:0]           rd_addr,
  output logic [LANES*LANE_W-1:0] rd_data
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
      if (wr_en && wr_be[g]) begin
        cells[wr_addr] <= wr_data[g*LANE_W +: LANE_W];
      end
    end

    assign rd_data[g*LANE_W +: LANE_W] = cells[rd_addr];
  end
endmodule

// File: rtl/turnfree_sram.sv
module turnfree_sram
  import turnfree_pkg::*;
#(
  parameter int unsigned LANES  = 4,
  parameter int unsigned LANE_W = 9,
  parameter int unsigned DEPTH  = 16,
  localparam int unsigned AW    = $clog2(DEPTH),
  localparam int unsigned W     = LANES * LANE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cke_n,
  input  logic             sel0_n,
  input  logic             sel1,
  input  logic             sel2_n,
  input  logic             burst_next,
  input  logic             wr_n,
  input  logic [AW-1:0]    addr,
  input  logic [LANES-1:0] lane_we_n,
  input  logic             oe_n,
  input  logic [W-1:0]     dq_in,
  output logic [W-1:0]     dq_out,
  output logic             dq_oe
);
  logic             pend_valid;
  op_e              pend_op;
  logic [AW-1:0]    pend_addr;
  logic [LANES-1:0] pend_be;
  logic             commit_wr;

  turnfree_ctrl #(.AW(AW), .LANES(LANES)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .cke_n      (cke_n),
    .sel0_n     (sel0_n),
    .sel1       (sel1),
    .sel2_n     (sel2_n),
    .burst_next (burst_next),
    .wr_n       (wr_n),
    .addr       (addr),
    .lane_we_n  (lane_we_n),
    .pend_valid (pend_valid),
    .pend_op    (pend_op),
    .pend_addr  (pend_addr),
    .pend_be    (pend_be)
  );

  assign commit_wr = !cke_n && pend_valid && (pend_op == OP_WR);

  turnfree_array #(.LANES(LANES), .LANE_W(LANE_W), .DEPTH(DEPTH), .AW(AW)) u_array (
    .clk     (clk),
    .wr_en   (commit_wr),
    .wr_addr (pend_addr),
    .wr_be   (pend_be),
    .wr_data (dq_in),
    .rd_addr (pend_addr),
    .rd_data (dq_out)
  );

  assign dq_oe = pend_valid && (pend_op == OP_RD) && !oe_n;

  AST_WRITE_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (!cke_n && !burst_next && !sel0_n && sel1 && !sel2_n && !wr_n) |=> !dq_oe); // R8

  AST_DESELECT_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (!cke_n && !burst_next && sel0_n) |=> !dq_oe); // R8
endmodule

// File: tb/turnfree_sram_bench.sv
module turnfree_sram_bench;
  localparam int unsigned LANES  = 4;
  localparam int unsigned LANE_W = 9;
  localparam int unsigned DEPTH  = 16;
  localparam int unsigned AW     = $clog2(DEPTH);
  localparam int unsigned W      = LANES * LANE_W;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic             rst_n = 1'b0, cke_n = 1'b0, sel0_n = 1'b1, sel1 = 1'b0, sel2_n = 1'b1;
  logic             burst_next = 1'b0, wr_n = 1'b1, oe_n = 1'b0;
  logic [AW-1:0]    addr = '0;
  logic [LANES-1:0] lane_we_n = '1;
  logic [W-1:0]     dq_in = '0;
  logic [W-1:0]     dq_out;
  logic             dq_oe;

  turnfree_sram #(.LANES(LANES), .LANE_W(LANE_W), .DEPTH(DEPTH)) u_turnfree_sram (
    .clk(clk), .rst_n(rst_n), .cke_n(cke_n), .sel0_n(sel0_n), .sel1(sel1), .sel2_n(sel2_n),
    .burst_next(burst_next), .wr_n(wr_n), .addr(addr), .lane_we_n(lane_we_n), .oe_n(oe_n),
    .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe)
  );

  logic [W-1:0]     mdl [DEPTH];
  logic             m_valid = 1'b0, m_wr = 1'b0;
  logic [AW-1:0]    m_addr = '0;
  logic [LANES-1:0] m_be = '0;
  int               n_cmp = 0, n_bad = 0;
  string            tag = "R11";
  logic             cke_v = 1'b0;
  logic [W-1:0]     scratch;

  function automatic logic [W-1:0] merge(logic [W-1:0] old_w, logic [W-1:0] new_w, logic [LANES-1:0] be);
    logic [W-1:0] r = old_w;
    for (int i = 0; i < LANES; i++) if (be[i]) r[i*LANE_W +: LANE_W] = new_w[i*LANE_W +: LANE_W];
    return r;
  endfunction

  function automatic logic [W-1:0] pat(int i);
    return W'(i * 32'h0123_4567 + 32'h89AB) ^ (W'(i) << 28);
  endfunction

  task automatic chk(bit ok, string what, logic [W-1:0] act, logic [W-1:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic check_bus();
    if (m_valid && !m_wr && !oe_n) begin
      chk(dq_oe === 1'b1, "dq_oe", W'(dq_oe), W'(1));
      chk(dq_out === mdl[m_addr], "dq_out", dq_out, mdl[m_addr]);
    end else begin
      chk(dq_oe === 1'b0, "dq_oe", W'(dq_oe), W'(0));
    end
  endtask

  task automatic step(logic c_n, logic s0n, logic s1, logic s2n, logic bn, logic w_n,
                      logic [AW-1:0] a, logic [LANES-1:0] be_n, logic [W-1:0] d);
    @(negedge clk);
    check_bus();
    cke_n = c_n; sel0_n = s0n; sel1 = s1; sel2_n = s2n; burst_next = bn;
    wr_n = w_n; addr = a; lane_we_n = be_n; dq_in = d;
    if (!c_n) begin
      if (m_valid && m_wr) mdl[m_addr] = merge(mdl[m_addr], d, m_be);
      if (!bn) begin
        m_valid = !s0n && s1 && !s2n;
        if (m_valid) begin m_wr = !w_n; m_addr = a; m_be = ~be_n; end
      end else if (m_valid) begin
        m_addr = (m_addr & ~AW'(3)) | ((m_addr + AW'(1)) & AW'(3));
        m_be = ~be_n;
      end
    end
  endtask

  // kind: 0 deselect, 1 read, 2 write, 3 advance
  task automatic cmd(int kind, logic [AW-1:0] a, logic [LANES-1:0] be_n, logic [W-1:0] d);
    step(cke_v, kind == 0, 1'b1, 1'b0, kind == 3, kind != 2, a, be_n, d);
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) mdl[i] = '0;
    repeat (3) @(negedge clk);
    chk(dq_oe === 1'b0, "dq_oe in reset", W'(dq_oe), W'(0)); // R11
    rst_n = 1'b1;
    cmd(0, 0, '0, '0);
    cmd(0, 0, '0, '0); // R11: nothing pending after release

    tag = "R2";
    for (int i = 0; i < DEPTH; i++) cmd(2, AW'(i), '0, (i == 0) ? '0 : pat(i - 1));
    cmd(0, 0, '0, pat(DEPTH - 1));

    tag = "R1";
    cmd(1, 3, '1, '0); cmd(1, 5, '1, '0); cmd(1, 0, '1, '0); cmd(0, 0, '1, '0); cmd(0, 0, '1, '0);

    tag = "R3";
    cmd(2, 7, '0, '0); cmd(1, 7, '0, pat(70)); cmd(2, 8, '0, '0); cmd(1, 8, '0, pat(80));
    cmd(2, 7, '0, '0); cmd(1, 7, '0, pat(71)); cmd(0, 0, '1, '0);

    tag = "R4";
    cmd(2, 9, 4'b1010, '0); cmd(1, 9, '1, '1); cmd(2, 10, 4'b0111, '0); cmd(1, 10, '1, '0);
    cmd(0, 0, '1, '0);

    tag = "R5";
    cmd(1, 2, '1, '0);
    cke_v = 1'b1; cmd(2, 5, '0, pat(99)); cmd(2, 5, '0, pat(98)); cmd(1, 6, '0, pat(97));
    cke_v = 1'b0; cmd(2, 4, '0, '0);
    cke_v = 1'b1; cmd(1, 6, '0, pat(96)); cmd(0, 6, '0, pat(95));
    cke_v = 1'b0; cmd(1, 4, '1, pat(44)); cmd(1, 5, '1, '0); cmd(0, 0, '1, '0);

    tag = "R6";
    step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 6, '0, '0);
    step(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 6, '0, pat(61));
    step(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 6, '0, pat(62));
    cmd(3, 6, '0, pat(63)); cmd(1, 6, '1, pat(64)); cmd(0, 0, '1, '0);

    tag = "R7";
    cmd(1, 3, '1, '0); cmd(0, 0, '1, '0); cmd(2, 3, '0, '0); cmd(0, 0, '1, pat(33));
    cmd(1, 3, '1, '0); cmd(0, 0, '1, '0);

    tag = "R8";
    cmd(1, 1, '1, '0); cmd(2, 2, '0, '0); cmd(1, 2, '1, pat(22)); cmd(0, 0, '1, '0); cmd(0, 0, '1, '0);

    tag = "R9";
    cmd(1, 5, '1, '0);
    @(posedge clk); #2;
    oe_n = 1'b1; #1;
    chk(dq_oe === 1'b0, "dq_oe async off", W'(dq_oe), W'(0));
    oe_n = 1'b0; #1;
    chk(dq_oe === 1'b1, "dq_oe async on", W'(dq_oe), W'(1));
    chk(dq_out === mdl[5], "dq_out async on", dq_out, mdl[5]);
    cmd(0, 0, '1, '0);

    tag = "R10";
    cmd(2, 13, '0, '0); cmd(3, 0, '0, pat(113)); cmd(3, 0, 4'b1100, pat(114));
    cmd(3, 0, '0, pat(115)); cmd(0, 0, '1, pat(112));
    cmd(1, 13, '1, '0); cmd(3, 0, '1, '0); cmd(3, 0, '1, '0); cmd(3, 0, '1, '0);
    cmd(3, 0, '1, '0); cmd(0, 0, '1, '0);
    cmd(0, 0, '1, '0); cmd(3, 0, '0, pat(7)); cmd(1, 12, '1, '0); cmd(0, 0, '1, '0);

    tag = "R3";
    void'($urandom(32'd1234));
    for (int k = 0; k < 3000; k++) begin
      scratch = {$urandom, $urandom};
      oe_n = ($urandom_range(0, 9) == 0);
      step(($urandom_range(0, 9) == 0), ($urandom_range(0, 11) == 0), ($urandom_range(0, 11) != 0),
           ($urandom_range(0, 11) == 0), ($urandom_range(0, 9) < 3), $urandom_range(0, 1) == 1,
           AW'($urandom), LANES'($urandom), scratch);
    end
    oe_n = 1'b0;
    cmd(0, 0, '1, '0);
    for (int i = 0; i < DEPTH; i++) cmd(1, AW'(i), '1, '0);
    cmd(0, 0, '1, '0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(64'd20 * 64'd200000);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog %s: actual hung expected done", tag);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule